// File: doc/BRIEF.md
# Texture-Unit Control Register Bank

This block is the software-facing register file of a texture-mapping engine. It keeps nineteen 32-bit words: a control word plus the geometry, buffer, level and key settings. These words describe one mapping pass. A host reaches them through a simple word-wide read/write bus. The rendering engine sits outside this block. It receives a one-cycle launch pulse, and it answers with a one-cycle completion strobe.

A small sequencer tracks each pass through four states. ST_IDLE waits for a launch request. ST_LAUNCH drives the launch pulse for one cycle. ST_RUN holds the busy flag until completion. ST_DONE raises the interrupt for one cycle and then returns to ST_IDLE. The transitions are named as follows. T_GO runs from ST_IDLE or ST_DONE to ST_LAUNCH on a control write with bit 0 set. T_ARMED runs from ST_LAUNCH to ST_RUN unconditionally. T_FINISH runs from ST_RUN to ST_DONE when the completion strobe arrives. T_REST runs from ST_DONE to ST_IDLE when no new request is present.

Value checks run on every write. Out-of-range levels, misaligned base addresses and illegal bus accesses each raise a sticky error bit. A write to the control word clears all of these bits.

Top module: `texmap_csr`

## Requirements
- R1: After reset, every word reads zero, and `engine_start`, `irq`, `chroma_en` and `err_flags` are all zero.
- R2: The word with index i sits at byte address 4*i. Index 0 is the control word. Indexes 1 to 18 are plain 32-bit storage that reads back the last value written. A read returns its data on `bus_rdata` in the cycle after the request. In the control word only bits 1:0 are held; the other bits read zero.
- R3: A valid control write with bit 0 set, made while the block is not busy, makes `engine_start` high for exactly the next cycle. From that cycle on, control bit 0 reads 1.
- R4: Control bit 0 stays 1 until `engine_done` is seen in the run state. In the cycle after that, bit 0 reads 0 and `irq` is high for exactly one cycle. A completion strobe seen while idle has no effect.
- R5: A control write with bit 0 set while busy gives no `engine_start` pulse, and bit 0 stays 1. Bit 1 of that write is still stored.
- R6: Control bit 1 (key colour enable) is stored by every valid control write, and it drives `chroma_en` from the next cycle on.
- R7: A write of a value above 63 to the gain word (index 3) sets `err_flags[0]`. The same for the opacity word (index 18) sets `err_flags[1]`. The value is still stored.
- R8: A write to the vertex base word (index 5) with any of bits 2:0 set raises `err_flags[2]`. A write to the texture base word (index 6) with bit 0 set raises `err_flags[3]`.
- R9: An access to a word index of 19 or more, with any byte-enable bit clear, or with byte address bits 1:0 not zero, is illegal. Such a read returns zero, such a write changes no word, and either one sets `err_flags[4]`.
- R10: Error bits are sticky across other writes and reads. A valid write to the control word clears all of them in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_be | input | 4 | Byte enables; all four must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| engine_start | output | 1 | One-cycle launch pulse to the engine |
| engine_done | input | 1 | One-cycle completion strobe from the engine |
| irq | output | 1 | One-cycle completion interrupt |
| chroma_en | output | 1 | Key colour enable (control bit 1) |
| err_flags | output | 5 | Sticky error bits: 0 gain, 1 opacity, 2 vertex align, 3 texture align, 4 bus |

## Verification
Every result of this block appears one clock edge after its stimulus. This covers the read data, the stored value, the error bits, `chroma_en`, the launch pulse after a control write, and the interrupt after the completion strobe. The bench drives each request at a falling edge and removes it at the next falling edge. It then samples at that second falling edge, which is half a cycle after the single edge that should have produced the result. For the pulses, the bench checks again one cycle later to confirm they have dropped.

// File: rtl/texmap_csr_pkg.sv
package texmap_csr_pkg;
    localparam int unsigned NUM_REGS  = 19;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned IDX_W     = $clog2(NUM_REGS);
    localparam int unsigned NUM_ERR   = 5;
    localparam int unsigned LEVEL_MAX = 63;

    typedef enum logic [IDX_W-1:0] {
        IX_CTRL, IX_MESH_XLAST, IX_MESH_YLAST, IX_GAIN, IX_KEYCOLOR,
        IX_VTX_BASE, IX_SRC_BASE, IX_SRC_W, IX_SRC_H, IX_SRC_WMASK,
        IX_SRC_HMASK, IX_DST_BASE, IX_DST_W, IX_DST_H, IX_DST_XOFS,
        IX_DST_YOFS, IX_TILE_W, IX_TILE_H, IX_OPACITY
    } reg_ix_e;

    localparam int unsigned ERR_GAIN = 0;
    localparam int unsigned ERR_OPAC = 1;
    localparam int unsigned ERR_VTX  = 2;
    localparam int unsigned ERR_SRC  = 3;
    localparam int unsigned ERR_BUS  = 4;

    typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_RUN, ST_DONE} seq_state_e;
endpackage

// File: rtl/texmap_csr_seq.sv
module texmap_csr_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic go_req,
    input  logic done_in,
    output logic busy,
    output logic start_o,
    output logic irq_o
);
    import texmap_csr_pkg::*;

    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (go_req)  state_d = ST_LAUNCH;
            ST_LAUNCH:              state_d = ST_RUN;
            ST_RUN:    if (done_in) state_d = ST_DONE;
            ST_DONE:   state_d = go_req ? ST_LAUNCH : ST_IDLE;
        endcase
    end

    always_comb begin
        start_o = 1'b0;
        irq_o   = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_LAUNCH: begin start_o = 1'b1; busy = 1'b1; end
            ST_RUN:    busy = 1'b1;
            ST_DONE:   irq_o = 1'b1;
        endcase
    end

    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);
    // R3
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
    // R4
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && done_in) |=> irq_o);
    // R5
    busy_nostart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go_req) |=> (!start_o && busy));
endmodule

// File: rtl/texmap_csr_chk.sv
module texmap_csr_chk #(
    parameter int unsigned LEVEL_LIMIT = 63,
    parameter int unsigned VTX_ALIGN_B = 3,
    parameter int unsigned SRC_ALIGN_B = 1
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_ok,
    input  logic [texmap_csr_pkg::IDX_W-1:0]      idx,
    input  logic [texmap_csr_pkg::DATA_W-1:0]     wdata,
    input  logic                                  bus_fault,
    output logic [texmap_csr_pkg::NUM_ERR-1:0]    err_q
);
    import texmap_csr_pkg::*;

    logic [NUM_ERR-1:0] hit;
    logic               clr;

    assign clr = wr_ok && (idx == IX_CTRL);

    always_comb begin
        hit = '0;
        hit[ERR_GAIN] = wr_ok && idx == IX_GAIN     && wdata > DATA_W'(LEVEL_LIMIT);
        hit[ERR_OPAC] = wr_ok && idx == IX_OPACITY  && wdata > DATA_W'(LEVEL_LIMIT);
        hit[ERR_VTX]  = wr_ok && idx == IX_VTX_BASE && |wdata[VTX_ALIGN_B-1:0];
        hit[ERR_SRC]  = wr_ok && idx == IX_SRC_BASE && |wdata[SRC_ALIGN_B-1:0];
        hit[ERR_BUS]  = bus_fault;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   err_q <= '0;
        else if (clr) err_q <= '0;
        else          err_q <= err_q | hit;
    end

    // R10
    ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_q == '0));
    // R9
    bus_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_fault |=> err_q[ERR_BUS]);
    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && err_q[ERR_GAIN]) |=> err_q[ERR_GAIN]);
endmodule

// File: rtl/texmap_csr_regs.sv
module texmap_csr_regs (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_ok,
    input  logic                              rd_ok,
    input  logic                              rd_bad,
    input  logic [texmap_csr_pkg::IDX_W-1:0]  idx,
    input  logic [texmap_csr_pkg::DATA_W-1:0] wdata,
    input  logic                              busy,
    output logic [texmap_csr_pkg::DATA_W-1:0] rdata_q,
    output logic                              chroma_q
);
    import texmap_csr_pkg::*;

    logic [DATA_W-1:0] store_q [NUM_REGS];
    logic [DATA_W-1:0] sel_val;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
            if (g == 0) begin : g_ctrl
                always_ff @(posedge clk) begin
                    if (!rst_n)                         chroma_q <= 1'b0;
                    else if (wr_ok && idx == IX_CTRL)   chroma_q <= wdata[1];
                end
                assign store_q[g] = {{(DATA_W-2){1'b0}}, chroma_q, busy};
            end else begin : g_plain
                logic [DATA_W-1:0] word_q;
                always_ff @(posedge clk) begin
                    if (!rst_n)                            word_q <= '0;
                    else if (wr_ok && idx == IDX_W'(g))    word_q <= wdata;
                end
                assign store_q[g] = word_q;
            end
        end
    endgenerate

    always_comb begin
        sel_val = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (idx == IDX_W'(i)) sel_val = store_q[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_bad) rdata_q <= '0;
        else if (rd_ok)  rdata_q <= sel_val;
    end

    // R9
    bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_bad |=> (rdata_q == '0));
    // R6
    chroma_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && idx == IX_CTRL) |=> (chroma_q == $past(wdata[1])));
endmodule

// File: rtl/texmap_csr.sv
module texmap_csr #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned VTX_ALIGN_B = 3,
    parameter int unsigned SRC_ALIGN_B = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              engine_start,
    input  logic              engine_done,
    output logic              irq,
    output logic              chroma_en,
    output logic [4:0]        err_flags
);
    import texmap_csr_pkg::*;

    localparam int unsigned WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    logic              legal, wr_ok, rd_ok, fault, rd_bad, go_req, busy;
    logic [IDX_W-1:0]  idx;

    assign word   = bus_addr[ADDR_W-1:2];
    assign idx    = word[IDX_W-1:0];
    assign legal  = (word < WORD_W'(NUM_REGS)) && (bus_be == 4'hF)
                    && (bus_addr[1:0] == 2'b00);
    assign wr_ok  = bus_sel && bus_wr && legal;
    assign rd_ok  = bus_sel && !bus_wr && legal;
    assign fault  = bus_sel && !legal;
    assign rd_bad = fault && !bus_wr;
    assign go_req = wr_ok && (idx == IX_CTRL) && bus_wdata[0];

    texmap_csr_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go_req(go_req), .done_in(engine_done),
        .busy(busy), .start_o(engine_start), .irq_o(irq)
    );

    texmap_csr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .rd_ok(rd_ok),
        .rd_bad(rd_bad), .idx(idx), .wdata(bus_wdata), .busy(busy),
        .rdata_q(bus_rdata), .chroma_q(chroma_en)
    );

    texmap_csr_chk #(
        .LEVEL_LIMIT(LEVEL_MAX), .VTX_ALIGN_B(VTX_ALIGN_B),
        .SRC_ALIGN_B(SRC_ALIGN_B)
    ) u_chk (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .idx(idx),
        .wdata(bus_wdata), .bus_fault(fault), .err_q(err_flags)
    );
endmodule

// File: tb/test_texmap_csr.sv
module test_texmap_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        engine_start, engine_done = 1'b0, irq, chroma_en;
    logic [4:0]  err_flags;
    int          checks = 0, errors = 0;
    logic [31:0] model [19];
    logic [31:0] rd;

    always #10 clk = ~clk;

    texmap_csr i_texmap_csr (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .engine_start(engine_start),
        .engine_done(engine_done), .irq(irq), .chroma_en(chroma_en),
        .err_flags(err_flags)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rdw(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_sel = 1'b0; bus_be = 4'hF;
        d = bus_rdata;
    endtask

    task automatic pulse_done();
        @(negedge clk); engine_done = 1'b1;
        @(negedge clk); engine_done = 1'b0;
    endtask

    task automatic finish_run();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 19; i++) begin
            rdw(8'(4*i), 4'hF, rd);
            check("R1 word", rd, 32'h0);
            model[i] = 32'h0;
        end
        check("R1 outs", {27'd0, engine_start, irq, chroma_en, 2'b0}, 32'h0);
        check("R1 err", {27'd0, err_flags}, 32'h0);

        // R2 storage sweep
        for (int i = 1; i < 19; i++) begin
            model[i] = 32'h5A000000 ^ (32'(i) * 32'h01030507);
            wr(8'(4*i), model[i], 4'hF);
        end
        for (int i = 1; i < 19; i++) begin
            rdw(8'(4*i), 4'hF, rd);
            check("R2 readback", rd, model[i]);
        end
        // R2/R6 control only keeps bits 1:0
        wr(8'h00, 32'hFFFF_FFFE, 4'hF);
        check("R6 chroma on", {31'd0, chroma_en}, 32'h1);
        rdw(8'h00, 4'hF, rd);
        check("R2 ctrl mask", rd, 32'h2);
        wr(8'h00, 32'h0, 4'hF);
        check("R6 chroma off", {31'd0, chroma_en}, 32'h0);

        // R7 level range sweep
        for (int v = 0; v < 128; v++) begin
            wr(8'h00, 32'h0, 4'hF);
            wr(8'd12, 32'(v), 4'hF);
            check("R7 gain flag", {31'd0, err_flags[0]}, {31'd0, v > 63});
            wr(8'd72, 32'(v), 4'hF);
            check("R7 opacity flag", {31'd0, err_flags[1]}, {31'd0, v > 63});
            rdw(8'd12, 4'hF, rd);
            check("R7 gain stored", rd, 32'(v));
        end
        model[3] = 32'd127; model[18] = 32'd127;

        // R8 alignment sweep
        for (int v = 0; v < 8; v++) begin
            wr(8'h00, 32'h0, 4'hF);
            wr(8'd20, 32'h1000 | 32'(v), 4'hF);
            check("R8 vertex flag", {31'd0, err_flags[2]}, {31'd0, v != 0});
            check("R8 vertex only", {31'd0, err_flags[3]}, 32'h0);
        end
        for (int v = 0; v < 4; v++) begin
            wr(8'h00, 32'h0, 4'hF);
            wr(8'd24, 32'h2000 | 32'(v), 4'hF);
            check("R8 texture flag", {31'd0, err_flags[3]}, {31'd0, v[0]});
        end
        model[5] = 32'h1007; model[6] = 32'h2003;

        // R10 sticky then cleared
        wr(8'h00, 32'h0, 4'hF);
        wr(8'd12, 32'd100, 4'hF);
        model[3] = 32'd100;
        wr(8'd28, 32'h55, 4'hF);
        model[7] = 32'h55;
        rdw(8'd28, 4'hF, rd);
        check("R10 sticky", {27'd0, err_flags}, 32'h1);
        wr(8'h00, 32'h0, 4'hF);
        check("R10 cleared", {27'd0, err_flags}, 32'h0);

        // R9 unknown words
        for (int w = 19; w < 64; w++) begin
            wr(8'h00, 32'h0, 4'hF);
            rdw(8'(4*w), 4'hF, rd);
            check("R9 unknown read", rd, 32'h0);
            check("R9 unknown read flag", {31'd0, err_flags[4]}, 32'h1);
            wr(8'h00, 32'h0, 4'hF);
            wr(8'(4*w), 32'hDEAD_BEEF, 4'hF);
            check("R9 unknown write flag", {31'd0, err_flags[4]}, 32'h1);
        end
        // R9 partial enables and low address bits
        for (int b = 0; b < 15; b++) begin
            wr(8'h00, 32'h0, 4'hF);
            wr(8'd4, 32'hFFFF_0000, 4'(b));
            check("R9 partial flag", {31'd0, err_flags[4]}, 32'h1);
            rdw(8'd4, 4'(b), rd);
            check("R9 partial read", rd, 32'h0);
        end
        for (int lo = 1; lo < 4; lo++) begin
            wr(8'h00, 32'h0, 4'hF);
            wr(8'(8 + lo), 32'h1234, 4'hF);
            check("R9 misaligned flag", {31'd0, err_flags[4]}, 32'h1);
        end
        for (int i = 1; i < 19; i++) begin
            rdw(8'(4*i), 4'hF, rd);
            check("R9 unchanged", rd, model[i]);
        end

        // R4 done while idle is ignored
        wr(8'h00, 32'h0, 4'hF);
        pulse_done();
        check("R4 idle done", {31'd0, irq}, 32'h0);

        // R3/R4 normal pass
        wr(8'h00, 32'h1, 4'hF);
        check("R3 start pulse", {31'd0, engine_start}, 32'h1);
        @(negedge clk);
        check("R3 start drops", {31'd0, engine_start}, 32'h0);
        rdw(8'h00, 4'hF, rd);
        check("R3 busy", rd, 32'h1);
        repeat (5) @(negedge clk);
        rdw(8'h00, 4'hF, rd);
        check("R4 still busy", rd, 32'h1);
        pulse_done();
        check("R4 irq", {31'd0, irq}, 32'h1);
        @(negedge clk);
        check("R4 irq drops", {31'd0, irq}, 32'h0);
        rdw(8'h00, 4'hF, rd);
        check("R4 busy clear", rd, 32'h0);

        // R5 start while busy ignored, bit 1 still stored
        wr(8'h00, 32'h1, 4'hF);
        check("R5 first start", {31'd0, engine_start}, 32'h1);
        @(negedge clk);
        wr(8'h00, 32'h3, 4'hF);
        check("R5 no restart", {31'd0, engine_start}, 32'h0);
        check("R5 chroma", {31'd0, chroma_en}, 32'h1);
        @(negedge clk);
        check("R5 no late start", {31'd0, engine_start}, 32'h0);
        rdw(8'h00, 4'hF, rd);
        check("R5 busy kept", rd, 32'h3);
        pulse_done();
        check("R5 irq", {31'd0, irq}, 32'h1);
        rdw(8'h00, 4'hF, rd);
        check("R5 idle", rd, 32'h2);

        finish_run();
    end
endmodule